// File: doc/BRIEF.md
# Early Receive Copy-Threshold Interrupt

This block tracks how many bytes of the frame now being received have been copied into host receive buffers. Software programs a byte threshold in four-byte steps. When the running byte count of a frame first reaches or passes that threshold, the block emits a single-cycle early-receive interrupt pulse. Host software can then start work on a frame before the frame has finished arriving.

The DMA side marks each frame with a start pulse and an end pulse. Between them it reports each copy beat with a strobe and a byte count from 1 to 4. The threshold is taken as a snapshot at frame start, so the count for each frame is compared against a fixed value. A frame raises the interrupt at most once.

Top module: `erx_early_irq`

## Requirements
- R1: After reset, `thr_rdata` reads 0x0000_03FC (threshold field all ones, the largest threshold of 1020 bytes), and `early_irq` is low.
- R2: A write with `thr_wr_en` stores `thr_wdata[9:2]` as the threshold field. Bits 31:10 and 1:0 of the write data are ignored. `thr_rdata` returns the field in bits 9:2 and zero in every other bit.
- R3: The byte threshold is the field value times four. `early_irq` pulses high for exactly one cycle, in the cycle after the counted beat that brings the frame's byte count to the threshold or above it.
- R4: The comparison is greater-or-equal. A multi-byte beat that jumps past the threshold without landing on it still raises the pulse.
- R5: At most one pulse is raised per frame. Beats after the pulse, in the same frame, raise no further pulses.
- R6: `frame_start` clears the byte count and re-arms the interrupt, and it also does so in the middle of a frame. A beat presented in the same cycle as `frame_start` is not counted.
- R7: A frame that ends before reaching its threshold raises no pulse. A beat in the same cycle as `frame_end` is counted. Beats that come after `frame_end` and before the next `frame_start` are not counted.
- R8: The threshold is captured at `frame_start`. A write in the middle of a frame has no effect on that frame and applies from the next frame onward.
- R9: A threshold field of zero makes the first counted beat of the frame raise the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_wr_en | input | 1 | Threshold register write strobe |
| thr_wdata | input | 32 | Threshold register write data (bits 9:2 used) |
| thr_rdata | output | 32 | Threshold register read data |
| frame_start | input | 1 | Pulse marking the start of a received frame |
| frame_end | input | 1 | Pulse marking the end of the frame |
| beat_valid | input | 1 | A copy beat into host memory occurs this cycle |
| beat_bytes | input | 3 | Bytes moved by the beat, 1 to 4 |
| early_irq | output | 1 | One-cycle early-receive interrupt pulse |

## Verification
The bench uses beat sizes that do not divide the threshold evenly. A strict-equality compare would let such a frame pass without any pulse. It keeps sending beats after the pulse and after the threshold is passed, so a design that does not remember it has fired would pulse again. It also places a beat in the same cycle as frame start and another after frame end, and a design that counts either of these would fire too early. Finally, it rewrites the threshold during a frame. A design without a snapshot would then fire on the new value for the frame in progress.

// File: rtl/erx_pkg.sv
package erx_pkg;
    localparam int unsigned THR_LSB = 2;
    localparam int unsigned THR_W   = 8;
    localparam int unsigned BEAT_W  = 3;
    localparam int unsigned CNT_W   = THR_W + THR_LSB + 2;
    localparam int unsigned REG_W   = 32;

    typedef struct packed {
        logic             active;
        logic             fired;
        logic             irq;
        logic [CNT_W-1:0] cnt;
        logic [THR_W-1:0] thr;
    } cnt_state_t;
endpackage

// File: rtl/erx_thr_reg.sv
module erx_thr_reg
    import erx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [THR_W-1:0] thr_field
);
    logic [THR_W-1:0] thr_d, thr_q;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata[REG_W-1:THR_W+THR_LSB], wdata[THR_LSB-1:0]};

    always_comb begin
        thr_d = thr_q;
        if (wr_en) thr_d = wdata[THR_LSB +: THR_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) thr_q <= '1;
        else        thr_q <= thr_d;
    end

    always_comb begin
        rdata = '0;
        rdata[THR_LSB +: THR_W] = thr_q;
    end
    assign thr_field = thr_q;

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rdata[THR_LSB +: THR_W] == $past(wdata[THR_LSB +: THR_W]));
    a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata));
endmodule

// File: rtl/erx_byte_count.sv
module erx_byte_count
    import erx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic [THR_W-1:0]  thr_field,
    output logic              irq
);
    cnt_state_t s_d, s_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sum_sat;
    logic [CNT_W-1:0] thr_bytes;

    always_comb begin
        sum       = {1'b0, s_q.cnt} + {{(CNT_W+1-BEAT_W){1'b0}}, beat_bytes};
        sum_sat   = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        thr_bytes = {{(CNT_W-THR_W-THR_LSB){1'b0}}, s_q.thr, {THR_LSB{1'b0}}};
        s_d       = s_q;
        s_d.irq   = 1'b0;
        if (frame_start) begin
            s_d.active = 1'b1;
            s_d.fired  = 1'b0;
            s_d.cnt    = '0;
            s_d.thr    = thr_field;
        end else if (s_q.active) begin
            if (beat_valid) begin
                s_d.cnt = sum_sat;
                if (!s_q.fired && sum_sat >= thr_bytes) begin
                    s_d.irq   = 1'b1;
                    s_d.fired = 1'b1;
                end
            end
            if (frame_end) s_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{active: 1'b0, fired: 1'b0, irq: 1'b0, cnt: '0, thr: '1};
        else        s_q <= s_d;
    end

    assign irq = s_q.irq;

    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r6_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(beat_valid && !frame_start));
    a_r5_once_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fired && !frame_start) |=> !irq);
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && !frame_start) |=> !irq);
endmodule

// File: rtl/erx_early_irq.sv
module erx_early_irq
    import erx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_wr_en,
    input  logic [31:0]       thr_wdata,
    output logic [31:0]       thr_rdata,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              beat_valid,
    input  logic [2:0]        beat_bytes,
    output logic              early_irq
);
    logic [THR_W-1:0] thr_field;

    erx_thr_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (thr_wr_en),
        .wdata     (thr_wdata),
        .rdata     (thr_rdata),
        .thr_field (thr_field)
    );

    erx_byte_count u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .beat_valid  (beat_valid),
        .beat_bytes  (beat_bytes),
        .thr_field   (thr_field),
        .irq         (early_irq)
    );
endmodule

// File: tb/erx_early_irq_tb.sv
`timescale 1ns/1ps
module erx_early_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        thr_wr_en = 1'b0;
    logic [31:0] thr_wdata = '0;
    logic [31:0] thr_rdata;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic        beat_valid = 1'b0;
    logic [2:0]  beat_bytes = '0;
    logic        early_irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    erx_early_irq u_dut (
        .clk(clk), .rst_n(rst_n), .thr_wr_en(thr_wr_en), .thr_wdata(thr_wdata),
        .thr_rdata(thr_rdata), .frame_start(frame_start), .frame_end(frame_end),
        .beat_valid(beat_valid), .beat_bytes(beat_bytes), .early_irq(early_irq)
    );

    // {threshold field, beat count, bytes per beat, beat index that fires or -1}
    localparam int VEC [6][4] = '{
        '{4, 4, 4, 3},    // R3 exact landing at 16 bytes
        '{5, 8, 3, 6},    // R4 jump past 20 bytes at 21
        '{2, 3, 2, -1},   // R7 frame ends at 6 of 8 bytes
        '{1, 6, 1, 3},    // R5 no second pulse after 4 bytes
        '{0, 2, 4, 0},    // R9 zero threshold
        '{3, 5, 4, 2}     // R3 12 bytes
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_thr(input logic [31:0] d);
        @(negedge clk); thr_wr_en = 1'b1; thr_wdata = d;
        @(negedge clk); thr_wr_en = 1'b0;
    endtask

    task automatic start_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic end_frame();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    // one beat, then sample the registered pulse and an idle cycle after it
    task automatic beat(input int nb, input logic exp_irq, input string req);
        @(negedge clk); beat_valid = 1'b1; beat_bytes = 3'(nb);
        @(negedge clk); beat_valid = 1'b0;
        chk(req, {31'b0, early_irq}, {31'b0, exp_irq});
        @(negedge clk);
        chk(req, {31'b0, early_irq}, 32'h0);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset readback", thr_rdata, 32'h0000_03FC);
        chk("R1 reset irq", {31'b0, early_irq}, 32'h0);

        for (int v = 0; v < 6; v++) begin
            wr_thr(32'(VEC[v][0]) << 2);
            start_frame();
            for (int b = 0; b < VEC[v][1]; b++)
                beat(VEC[v][2], b == VEC[v][3], $sformatf("R3/R4/R5/R7/R9 vec%0d beat%0d", v, b));
            end_frame();
        end

        // R2 ignored bits
        wr_thr(32'hFFFF_F817);
        chk("R2 readback masked", thr_rdata, 32'h0000_0014);

        // R6 beat alongside start is not counted
        wr_thr(32'h4);
        @(negedge clk); frame_start = 1'b1; beat_valid = 1'b1; beat_bytes = 3'd4;
        @(negedge clk); frame_start = 1'b0; beat_valid = 1'b0;
        chk("R6 beat with start", {31'b0, early_irq}, 32'h0);
        beat(3, 1'b0, "R6 count restarted");
        start_frame();
        beat(3, 1'b0, "R6 mid-frame restart clears");
        beat(1, 1'b1, "R6 fires at 4 after restart");
        end_frame();

        // R7 beat after end not counted; beat with end counted
        start_frame();
        beat(2, 1'b0, "R7 partial");
        end_frame();
        beat(4, 1'b0, "R7 beat after end");
        start_frame();
        beat(3, 1'b0, "R7 pre-end");
        @(negedge clk); beat_valid = 1'b1; beat_bytes = 3'd1; frame_end = 1'b1;
        @(negedge clk); beat_valid = 1'b0; frame_end = 1'b0;
        chk("R7 beat with end counted", {31'b0, early_irq}, 32'h1);

        // R8 mid-frame write deferred
        wr_thr(32'h8);
        start_frame();
        wr_thr(32'h4);
        beat(4, 1'b0, "R8 old threshold held");
        beat(4, 1'b1, "R8 fires at 8");
        end_frame();
        start_frame();
        beat(4, 1'b1, "R8 new threshold next frame");
        end_frame();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule